// File: doc/BRIEF.md
# T1 Transmit Alarm and Loop Code Inserter

This block sits in the transmit path of a T1 framer, ahead of the line encoder. It receives the outgoing DS1 stream one bit per enabled clock, with strobes that mark each bit's place in the frame:
- the framing overhead position,
- the facility data link slot,
- the frame number within the multiframe,
- the channel number,
- the bit index within the channel.

A set of control inputs selects the maintenance and alarm codes. The block returns the line bit with those codes overlaid, one register stage later.

There are three replacement codes: transmit all ones, the 00001 loop-up code and the 001 loop-down code. Each can be sent framed or unframed. In framed mode the incoming overhead bit is kept and the code fills only the payload. In unframed mode the code replaces every bit. When no replacement code is active, the block can overlay three yellow alarms:
- the extended-superframe yellow pattern on the data link slots, with a variant for the regional (Japan) mode;
- the superframe yellow alarm, which clears bit 2 of every channel;
- the superframe secondary yellow alarm, which sets the overhead bit of frame 12.

Top module: `t1_alarm_inserter`

## Requirements
- R1: After reset, and until the first enabled bit, `line_o` and `line_valid_o` are 0.
- R2: For each bit presented with `bit_en_i` high, `line_o` and `line_valid_o` (=1) appear one clock later. With no code or alarm active, `line_o` equals `data_i`. A cycle with `bit_en_i` low gives `line_valid_o` 0.
- R3: While `all_ones_n_i` is 0 (active low) and overhead keep is off, every output bit is 1.
- R4: While loop-up is the selected code, its bits repeat 0,0,0,0,1, starting with the first 0.
- R5: While loop-down is the selected code, its bits repeat 0,0,1, starting with the first 0.
- R6: With `oh_keep_i` = 0, the selected replacement code also replaces the bits at overhead positions (`oh_pos_i` = 1).
- R7: With `oh_keep_i` = 1, overhead positions carry `data_i` unchanged while a replacement code is active. The loop code phase advances only on payload bits, so the pattern runs on unbroken across the overhead bits.
- R8: Priority is all ones (highest), then loop-up, then loop-down. No yellow alarm is applied while any of these three is active.
- R9: With `esf_mode_i` = 1, `esf_yel_i` = 1 and `japan_mode_i` = 0, the data link slots (`dl_pos_i` = 1) carry eight 1s then eight 0s, repeating, starting with the 1s. Other bits pass `data_i`.
- R10: With `esf_mode_i` = 1, `esf_yel_i` = 1 and `japan_mode_i` = 1, every data link slot carries 1.
- R11: With `esf_mode_i` = 0 and `d4_yel_i` = 1, the second transmitted bit of each channel (`bit_idx_i` = 1, where index 0 is the first bit) is forced to 0 for channels 0 to 23.
- R12: With `esf_mode_i` = 0 and `d4_sec_yel_i` = 1, the overhead bit of frame 12 (`frame_num_i` = 12) is forced to 1. Other overhead bits pass through.
- R13: Each pattern phase restarts from the beginning of its pattern whenever its code becomes selected again after being deselected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| bit_en_i | input | 1 | A stream bit is present this cycle |
| data_i | input | 1 | Incoming DS1 bit |
| oh_pos_i | input | 1 | Bit is a framing overhead position |
| dl_pos_i | input | 1 | Bit is a facility data link slot |
| frame_num_i | input | 5 | Frame number within the multiframe, from 1 |
| chan_num_i | input | 5 | Channel number, 0 to 23 |
| bit_idx_i | input | 3 | Bit index within the channel, 0 = first sent |
| esf_mode_i | input | 1 | 1 = extended superframe, 0 = superframe |
| japan_mode_i | input | 1 | Regional variant of the data link yellow pattern |
| esf_yel_i | input | 1 | Extended-superframe yellow alarm enable |
| d4_yel_i | input | 1 | Superframe yellow alarm enable |
| d4_sec_yel_i | input | 1 | Superframe secondary yellow alarm enable |
| all_ones_n_i | input | 1 | Transmit all ones, active low |
| loop_up_i | input | 1 | Loop-up code enable |
| loop_dn_i | input | 1 | Loop-down code enable |
| oh_keep_i | input | 1 | 1 = framed codes (overhead kept), 0 = unframed |
| line_o | output | 1 | Output line bit |
| line_valid_o | output | 1 | `line_o` holds a new bit |

## Verification
Every result comes out of one register stage. The output bit for a strobe presented before clock edge N is visible after edge N, and a pattern phase that steps on that bit is used for the next enabled bit. The bench changes inputs on the falling edge and reads `line_o` on the following falling edge, so it sees the bit driven half a cycle earlier. A reference phase counter in the bench steps only on the bits that the requirements say the code occupies.

// File: rtl/t1ai_pkg.sv
package t1ai_pkg;
    typedef enum logic [1:0] {
        SRC_NONE = 2'd0,
        SRC_ONES = 2'd1,
        SRC_LUP  = 2'd2,
        SRC_LDN  = 2'd3
    } code_src_e;

    typedef struct packed {
        logic line;
        logic valid;
    } out_reg_t;
endpackage

// File: rtl/t1ai_phase_ctr.sv
module t1ai_phase_ctr #(
    parameter int LEN = 5,
    localparam int PW = (LEN > 1) ? $clog2(LEN) : 1
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          clear_i,
    input  logic          step_i,
    output logic [PW-1:0] phase_o,
    output logic          last_o
);
    localparam logic [PW-1:0] LAST = PW'(LEN - 1);

    logic [PW-1:0] phase_d, phase_q;

    always_comb begin
        phase_d = phase_q;
        if (clear_i) begin
            phase_d = '0;
        end else if (step_i) begin
            phase_d = (phase_q == LAST) ? '0 : phase_q + 1'b1;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) phase_q <= '0;
        else         phase_q <= phase_d;
    end

    assign phase_o = phase_q;
    assign last_o  = (phase_q == LAST);
endmodule

// File: rtl/t1ai_code_arb.sv
module t1ai_code_arb
    import t1ai_pkg::*;
(
    input  logic      all_ones_n_i,
    input  logic      loop_up_i,
    input  logic      loop_dn_i,
    output code_src_e src_o
);
    always_comb begin
        if (!all_ones_n_i)   src_o = SRC_ONES;
        else if (loop_up_i)  src_o = SRC_LUP;
        else if (loop_dn_i)  src_o = SRC_LDN;
        else                 src_o = SRC_NONE;
    end
endmodule

// File: rtl/t1ai_yellow.sv
module t1ai_yellow #(
    parameter int FRAME_W   = 5,
    parameter int CHAN_W    = 5,
    parameter int BIT_W     = 3,
    parameter int NUM_CHAN  = 24,
    parameter int SEC_FRAME = 12,
    parameter int YEL_BIT   = 1,
    parameter int YEL_RUN   = 8,
    localparam int YW = $clog2(2 * YEL_RUN)
) (
    input  logic               esf_mode_i,
    input  logic               japan_mode_i,
    input  logic               esf_yel_i,
    input  logic               d4_yel_i,
    input  logic               d4_sec_yel_i,
    input  logic               oh_pos_i,
    input  logic               dl_pos_i,
    input  logic [FRAME_W-1:0] frame_num_i,
    input  logic [CHAN_W-1:0]  chan_num_i,
    input  logic [BIT_W-1:0]   bit_idx_i,
    input  logic [YW-1:0]      esf_phase_i,
    output logic               hit_o,
    output logic               val_o
);
    localparam logic [YW-1:0]      RUN_END = YW'(YEL_RUN);
    localparam logic [FRAME_W-1:0] SEC_FR  = FRAME_W'(SEC_FRAME);
    localparam logic [BIT_W-1:0]   Y_BIT   = BIT_W'(YEL_BIT);
    localparam logic [CHAN_W-1:0]  N_CH    = CHAN_W'(NUM_CHAN);

    always_comb begin
        hit_o = 1'b0;
        val_o = 1'b0;
        if (esf_mode_i) begin
            if (esf_yel_i && dl_pos_i) begin
                hit_o = 1'b1;
                val_o = japan_mode_i ? 1'b1 : (esf_phase_i < RUN_END);
            end
        end else begin
            if (d4_sec_yel_i && oh_pos_i && frame_num_i == SEC_FR) begin
                hit_o = 1'b1;
                val_o = 1'b1;
            end else if (d4_yel_i && !oh_pos_i && bit_idx_i == Y_BIT
                         && chan_num_i < N_CH) begin
                hit_o = 1'b1;
                val_o = 1'b0;
            end
        end
    end
endmodule

// File: rtl/t1_alarm_inserter.sv
module t1_alarm_inserter
    import t1ai_pkg::*;
#(
    parameter int FRAME_W   = 5,
    parameter int CHAN_W    = 5,
    parameter int BIT_W     = 3,
    parameter int NUM_CHAN  = 24,
    parameter int SEC_FRAME = 12,
    parameter int YEL_BIT   = 1,
    parameter int LUP_LEN   = 5,
    parameter int LDN_LEN   = 3,
    parameter int YEL_RUN   = 8
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               bit_en_i,
    input  logic               data_i,
    input  logic               oh_pos_i,
    input  logic               dl_pos_i,
    input  logic [FRAME_W-1:0] frame_num_i,
    input  logic [CHAN_W-1:0]  chan_num_i,
    input  logic [BIT_W-1:0]   bit_idx_i,
    input  logic               esf_mode_i,
    input  logic               japan_mode_i,
    input  logic               esf_yel_i,
    input  logic               d4_yel_i,
    input  logic               d4_sec_yel_i,
    input  logic               all_ones_n_i,
    input  logic               loop_up_i,
    input  logic               loop_dn_i,
    input  logic               oh_keep_i,
    output logic               line_o,
    output logic               line_valid_o
);
    localparam int YEL_LEN = 2 * YEL_RUN;
    localparam int YW      = $clog2(YEL_LEN);
    localparam int LUW     = (LUP_LEN > 1) ? $clog2(LUP_LEN) : 1;
    localparam int LDW     = (LDN_LEN > 1) ? $clog2(LDN_LEN) : 1;

    code_src_e src;
    logic      code_owns, code_bit;
    logic      lup_step, lup_clr, lup_last;
    logic      ldn_step, ldn_clr, ldn_last;
    logic      yel_step, yel_clr, yel_active;
    logic      yel_hit, yel_val;
    logic [LUW-1:0] lup_phase;
    logic [LDW-1:0] ldn_phase;
    logic [YW-1:0]  yel_phase;
    out_reg_t  out_d, out_q;

    t1ai_code_arb u_arb (
        .all_ones_n_i (all_ones_n_i),
        .loop_up_i    (loop_up_i),
        .loop_dn_i    (loop_dn_i),
        .src_o        (src)
    );

    t1ai_phase_ctr #(.LEN(LUP_LEN)) u_lup_ctr (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .clear_i (lup_clr),
        .step_i  (lup_step),
        .phase_o (lup_phase),
        .last_o  (lup_last)
    );

    t1ai_phase_ctr #(.LEN(LDN_LEN)) u_ldn_ctr (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .clear_i (ldn_clr),
        .step_i  (ldn_step),
        .phase_o (ldn_phase),
        .last_o  (ldn_last)
    );

    t1ai_phase_ctr #(.LEN(YEL_LEN)) u_yel_ctr (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .clear_i (yel_clr),
        .step_i  (yel_step),
        .phase_o (yel_phase),
        .last_o  ()
    );

    t1ai_yellow #(
        .FRAME_W   (FRAME_W),
        .CHAN_W    (CHAN_W),
        .BIT_W     (BIT_W),
        .NUM_CHAN  (NUM_CHAN),
        .SEC_FRAME (SEC_FRAME),
        .YEL_BIT   (YEL_BIT),
        .YEL_RUN   (YEL_RUN)
    ) u_yel (
        .esf_mode_i   (esf_mode_i),
        .japan_mode_i (japan_mode_i),
        .esf_yel_i    (esf_yel_i),
        .d4_yel_i     (d4_yel_i),
        .d4_sec_yel_i (d4_sec_yel_i),
        .oh_pos_i     (oh_pos_i),
        .dl_pos_i     (dl_pos_i),
        .frame_num_i  (frame_num_i),
        .chan_num_i   (chan_num_i),
        .bit_idx_i    (bit_idx_i),
        .esf_phase_i  (yel_phase),
        .hit_o        (yel_hit),
        .val_o        (yel_val)
    );

    // Code selection, phase control and next output bit
    always_comb begin
        code_owns = (src != SRC_NONE) && !(oh_keep_i && oh_pos_i);
        unique case (src)
            SRC_ONES: code_bit = 1'b1;
            SRC_LUP:  code_bit = lup_last;
            SRC_LDN:  code_bit = ldn_last;
            default:  code_bit = 1'b0;
        endcase

        lup_clr    = (src != SRC_LUP);
        lup_step   = bit_en_i && (src == SRC_LUP) && code_owns;
        ldn_clr    = (src != SRC_LDN);
        ldn_step   = bit_en_i && (src == SRC_LDN) && code_owns;
        yel_active = (src == SRC_NONE) && esf_mode_i && esf_yel_i;
        yel_clr    = !yel_active;
        yel_step   = bit_en_i && yel_active && dl_pos_i;

        out_d = out_q;
        out_d.valid = bit_en_i;
        if (bit_en_i) begin
            if (code_owns)
                out_d.line = code_bit;
            else if (src == SRC_NONE && yel_hit)
                out_d.line = yel_val;
            else
                out_d.line = data_i;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) out_q <= '0;
        else         out_q <= out_d;
    end

    assign line_o       = out_q.line;
    assign line_valid_o = out_q.valid;
endmodule

// File: rtl/t1ai_checker.sv
module t1ai_checker #(
    parameter int FRAME_W = 5,
    parameter int BIT_W   = 3
) (
    input logic               clk_i,
    input logic               rst_ni,
    input logic               bit_en_i,
    input logic               data_i,
    input logic               oh_pos_i,
    input logic [FRAME_W-1:0] frame_num_i,
    input logic [BIT_W-1:0]   bit_idx_i,
    input logic               esf_mode_i,
    input logic               d4_yel_i,
    input logic               d4_sec_yel_i,
    input logic               all_ones_n_i,
    input logic               loop_up_i,
    input logic               loop_dn_i,
    input logic               oh_keep_i,
    input logic               line_o,
    input logic               line_valid_o
);
    logic any_code;
    assign any_code = !all_ones_n_i || loop_up_i || loop_dn_i;

    assert_valid_follows_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        bit_en_i |=> line_valid_o);

    assert_idle_no_valid_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !bit_en_i |=> !line_valid_o);

    assert_all_ones_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (bit_en_i && !all_ones_n_i && !oh_keep_i) |=> line_o);

    assert_framed_oh_pass_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (bit_en_i && any_code && oh_keep_i && oh_pos_i) |=> (line_o == $past(data_i)));

    assert_d4_yellow_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (bit_en_i && !any_code && !esf_mode_i && d4_yel_i && !oh_pos_i
         && bit_idx_i == BIT_W'(1)) |=> !line_o);

    assert_d4_sec_yellow_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (bit_en_i && !any_code && !esf_mode_i && d4_sec_yel_i && oh_pos_i
         && frame_num_i == FRAME_W'(12)) |=> line_o);
endmodule

bind t1_alarm_inserter t1ai_checker #(.FRAME_W(FRAME_W), .BIT_W(BIT_W)) u_chk (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .bit_en_i     (bit_en_i),
    .data_i       (data_i),
    .oh_pos_i     (oh_pos_i),
    .frame_num_i  (frame_num_i),
    .bit_idx_i    (bit_idx_i),
    .esf_mode_i   (esf_mode_i),
    .d4_yel_i     (d4_yel_i),
    .d4_sec_yel_i (d4_sec_yel_i),
    .all_ones_n_i (all_ones_n_i),
    .loop_up_i    (loop_up_i),
    .loop_dn_i    (loop_dn_i),
    .oh_keep_i    (oh_keep_i),
    .line_o       (line_o),
    .line_valid_o (line_valid_o)
);

// File: tb/t1_alarm_inserter_tb.sv
module t1_alarm_inserter_tb;
    localparam time CLK_HALF = 4ns;

    logic clk = 1'b0, rst_n = 1'b0;
    logic bit_en = 0, data = 0, oh_pos = 0, dl_pos = 0;
    logic [4:0] frame_num = 5'd1, chan_num = 0;
    logic [2:0] bit_idx = 0;
    logic esf_mode = 0, japan = 0, esf_yel = 0, d4_yel = 0, d4_sec = 0;
    logic all_ones_n = 1, loop_up = 0, loop_dn = 0, oh_keep = 0;
    logic line, line_valid;

    int n_checks = 0, n_fail = 0;
    int pos = 0, frame = 1;
    bit done = 0;

    always #CLK_HALF clk = ~clk;

    t1_alarm_inserter u_dut (
        .clk_i(clk), .rst_ni(rst_n), .bit_en_i(bit_en), .data_i(data),
        .oh_pos_i(oh_pos), .dl_pos_i(dl_pos), .frame_num_i(frame_num),
        .chan_num_i(chan_num), .bit_idx_i(bit_idx), .esf_mode_i(esf_mode),
        .japan_mode_i(japan), .esf_yel_i(esf_yel), .d4_yel_i(d4_yel),
        .d4_sec_yel_i(d4_sec), .all_ones_n_i(all_ones_n), .loop_up_i(loop_up),
        .loop_dn_i(loop_dn), .oh_keep_i(oh_keep), .line_o(line),
        .line_valid_o(line_valid)
    );

    function automatic bit is_oh();
        return pos == 0;
    endfunction

    function automatic bit is_dl();
        return esf_mode && pos == 0 && frame[0];
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d (frame %0d pos %0d)", req, act, exp, frame, pos);
        end
    endtask

    task automatic start(input bit esf);
        esf_mode = esf; pos = 0; frame = 1;
    endtask

    task automatic clear_ctl();
        japan = 0; esf_yel = 0; d4_yel = 0; d4_sec = 0;
        all_ones_n = 1; loop_up = 0; loop_dn = 0; oh_keep = 0;
    endtask

    // One stream bit: drive at falling edge, read at the next falling edge
    task automatic tx(input bit d, input bit exp, input string req);
        @(negedge clk);
        bit_en = 1; data = d; oh_pos = is_oh(); dl_pos = is_dl();
        frame_num = 5'(frame);
        chan_num  = (pos == 0) ? 5'd0 : 5'((pos - 1) / 8);
        bit_idx   = (pos == 0) ? 3'd0 : 3'((pos - 1) % 8);
        @(negedge clk);
        bit_en = 0;
        check(line == exp && line_valid, req, line, exp);
        pos++;
        if (pos == 193) begin
            pos = 0;
            frame = (frame == (esf_mode ? 24 : 12)) ? 1 : frame + 1;
        end
    endtask

    task automatic quiet();
        clear_ctl();
        tx(1'b0, 1'b0, "R2");
    endtask

    task automatic t_reset();
        check(line == 0, "R1 line", line, 0);
        check(line_valid == 0, "R1 valid", line_valid, 0);
    endtask

    task automatic t_pass();
        clear_ctl(); start(0);
        for (int i = 0; i < 400; i++) tx(1'(i % 3 == 0), 1'(i % 3 == 0), "R2 pass");
        @(negedge clk);
        check(line_valid == 0, "R2 idle", line_valid, 0);
    endtask

    task automatic t_ones(input bit framed);
        quiet(); start(0);
        all_ones_n = 0; oh_keep = framed;
        for (int i = 0; i < 400; i++) begin
            bit d = 1'(i % 2);
            tx(d, (framed && is_oh()) ? d : 1'b1, framed ? "R7 ones" : "R3 R6 ones");
        end
    endtask

    task automatic t_loop(input bit up, input bit framed, input int n);
        int len = up ? 5 : 3;
        int k = 0;
        quiet(); start(0);
        loop_up = up; loop_dn = !up; oh_keep = framed;
        for (int i = 0; i < n; i++) begin
            if (framed && is_oh()) tx(1'b1, 1'b1, "R7 oh kept");
            else begin
                tx(1'b0, 1'(k % len == len - 1), up ? "R4 R6 loop-up" : "R5 R6 loop-down");
                k++;
            end
        end
    endtask

    task automatic t_restart();
        int k = 0;
        quiet(); start(0);
        loop_up = 1;
        for (int i = 0; i < 7; i++) begin tx(1'b0, 1'(i % 5 == 4), "R13 pre"); end
        loop_up = 0;
        tx(1'b1, 1'b1, "R13 gap");
        loop_up = 1;
        for (int i = 0; i < 10; i++) begin tx(1'b1, 1'(k % 5 == 4), "R13 restart"); k++; end
    endtask

    task automatic t_priority();
        quiet(); start(0);
        all_ones_n = 0; loop_up = 1; loop_dn = 1;
        for (int i = 0; i < 10; i++) tx(1'b0, 1'b1, "R8 ones wins");
        quiet(); start(0);
        loop_up = 1; loop_dn = 1;
        for (int i = 0; i < 10; i++) tx(1'b0, 1'(i % 5 == 4), "R8 loop-up wins");
        quiet(); start(0);
        loop_dn = 1; d4_yel = 1; d4_sec = 1; oh_keep = 1;
        for (int k = 0; k < 193 * 12; ) begin
            if (is_oh()) tx(1'b0, 1'b0, "R8 no yellow");
            else begin tx(1'b1, 1'(k % 3 == 2), "R8 no yellow"); k++; end
        end
    endtask

    task automatic t_esf_yel(input bit jp);
        int k = 0;
        quiet(); start(1);
        esf_yel = 1; japan = jp;
        for (int i = 0; i < 193 * 48; i++) begin
            bit d = 1'(pos % 2);
            if (is_dl()) begin
                tx(1'b0, jp ? 1'b1 : 1'((k % 16) < 8), jp ? "R10 japan" : "R9 esf yellow");
                k++;
            end else tx(d, d, "R9 other bits");
        end
    endtask

    task automatic t_d4_yel();
        quiet(); start(0);
        d4_yel = 1;
        for (int i = 0; i < 193 * 12; i++) begin
            bit hit = !is_oh() && ((pos - 1) % 8 == 1);
            tx(1'b1, !hit, "R11 d4 yellow");
        end
    endtask

    task automatic t_d4_sec();
        quiet(); start(0);
        d4_sec = 1;
        for (int i = 0; i < 193 * 24; i++) begin
            bit hit = is_oh() && frame == 12;
            tx(1'b0, hit, "R12 secondary yellow");
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_pass();
        t_ones(0);
        t_ones(1);
        t_loop(1, 0, 400);
        t_loop(0, 0, 400);
        t_loop(1, 1, 600);
        t_loop(0, 1, 600);
        t_restart();
        t_priority();
        t_esf_yel(0);
        t_esf_yel(1);
        t_d4_yel();
        t_d4_sec();
        done = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule